// File: doc/BRIEF.md
# Frame-Timed Bus Write Replayer

This block takes control of a host 8-bit computer's bus and replays a list of preloaded writes, each placed on one exact host clock cycle of a video frame. The host loads the list into an internal table through a simple write port. It then arms the block. The block pulls the DMA request low, counts host clock cycles from a frame sync pulse, and drives the address and data buses in the CPU half of each cycle that a list entry names.

Each table slot holds three things: a 15-bit frame cycle index, a 16-bit address and an 8-bit data byte. The host computes the index from the raster line and the cycle within that line. Slots are used in table order. When the last slot has been used, the block releases DMA and drives nothing more. The host can also hold the computer in reset.

Top module: `frame_write_replayer`

## Requirements
- R1: After synchronous reset, `dma_n` and `reset_n` are 1, and `addr_oe`, `data_oe` and `missed` are 0.
- R2: An `arm` pulse with a nonzero `sched_len` pulls `dma_n` low on the next clock. The pointer restarts at slot 0 and `missed` is cleared. With `sched_len` = 0, `dma_n` stays 1.
- R3: A host cycle starts where `cpu_phase` rises, and its frame index is the counter value at that point. The counter goes to 0 on `frame_sync`, which wins over advancing. Otherwise it adds 1 on each fall of `cpu_phase`, and it returns to 0 after reaching `cycles_per_frame`-1.
- R4: The current slot fires in the host cycle whose frame index equals its stored index. Slots fire strictly in slot order. A later slot whose index has already passed waits until the counter wraps round to it.
- R5: When a slot fires, `addr_oe` goes high from the first clock after `cpu_phase` rises until `cpu_phase` falls, and `bus_addr` carries the slot's address.
- R6: `data_oe` rises one clock after `addr_oe`, with `bus_data` carrying the slot's byte. Neither enable is ever high while `cpu_phase` is 0.
- R7: If `bus_avail` is 0 when the current slot is due, nothing is driven and `missed` is set. The slot then fires at the first later host cycle that starts with `bus_avail` high. `missed` stays set until the next `arm`.
- R8: After the last slot has fired, `dma_n` returns to 1 on the first clock of the following video half, and nothing further is driven.
- R9: `reset_n` equals the inverse of `host_reset`, delayed by one clock.
- R10: A write on the load port stores the index, address and byte into slot `ld_slot`. Replay uses exactly those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the host clock phase |
| rst | input | 1 | Synchronous active-high reset |
| cpu_phase | input | 1 | Host clock phase, 1 during the CPU half |
| bus_avail | input | 1 | Host bus-available signal, 1 when the bus may be taken |
| frame_sync | input | 1 | Frame start pulse; zeroes the cycle counter |
| cycles_per_frame | input | 15 | Host cycles in one frame |
| ld_we | input | 1 | Table write strobe |
| ld_slot | input | 6 | Table slot written |
| ld_index | input | 15 | Frame cycle index for the slot |
| ld_addr | input | 16 | Address for the slot |
| ld_data | input | 8 | Data byte for the slot |
| sched_len | input | 7 | Number of slots to replay |
| arm | input | 1 | Start pulse for replay |
| host_reset | input | 1 | Host request to hold the computer in reset |
| bus_addr | output | 16 | Address driven onto the host bus |
| addr_oe | output | 1 | Drive enable for all 16 address lines |
| bus_data | output | 8 | Data driven onto the host bus |
| data_oe | output | 1 | Drive enable for the data lines |
| dma_n | output | 1 | Active-low DMA request |
| reset_n | output | 1 | Active-low reset to the host computer |
| missed | output | 1 | Sticky flag: a slot was due while the bus was unavailable |

## Verification
A wrong frame counter value shows up as a write in the wrong host cycle. It appears at the first due slot after the fault, and a wrap or sync error shifts every later write by the same number of cycles. A slot pointer that is one step off shows the address and byte of a neighbouring slot in that same CPU half. A stale active flag shows up as `dma_n` staying low into the first video half after the last write. A lost late marker shows up as a waiting write never appearing in the cycle after `bus_avail` returns.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

    localparam int IDX_W  = 15;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sched_entry_t;

    localparam int ENTRY_W = $bits(sched_entry_t);

    function automatic sched_entry_t make_entry(
        input logic [IDX_W-1:0]  idx,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] data
    );
        sched_entry_t e;
        e.idx  = idx;
        e.addr = addr;
        e.data = data;
        return e;
    endfunction

endpackage

// File: rtl/fwr_frame_counter.sv
module fwr_frame_counter
    import fwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cycle_end,
    input  logic             frame_sync,
    input  logic [IDX_W-1:0] cycles_per_frame,
    output logic [IDX_W-1:0] count
);
    logic [IDX_W-1:0] last_idx;
    assign last_idx = cycles_per_frame - IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (frame_sync) begin
            count <= '0;
        end else if (cycle_end) begin
            if (count >= last_idx) count <= '0;
            else                   count <= count + IDX_W'(1);
        end
    end
endmodule

// File: rtl/fwr_sched_mem.sv
module fwr_sched_mem
    import fwr_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  sched_entry_t      wentry,
    input  logic [SLOT_W-1:0] rslot,
    output sched_entry_t      rentry
);
    sched_entry_t table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) table_q[wslot] <= wentry;
    end

    assign rentry = table_q[rslot];
endmodule

// File: rtl/fwr_bus_driver.sv
module fwr_bus_driver
    import fwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_phase,
    input  logic              fire,
    input  sched_entry_t      entry,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              addr_oe,
    output logic [DATA_W-1:0] bus_data,
    output logic              data_oe
);
    logic addr_stage_q;
    logic data_stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_stage_q <= 1'b0;
            data_stage_q <= 1'b0;
            bus_addr     <= '0;
            bus_data     <= '0;
        end else begin
            if (fire) begin
                addr_stage_q <= 1'b1;
                bus_addr     <= entry.addr;
                bus_data     <= entry.data;
            end else if (!cpu_phase) begin
                addr_stage_q <= 1'b0;
            end
            data_stage_q <= addr_stage_q & cpu_phase;
        end
    end

    // Enables are gated by the phase so the bus is freed the moment the video half begins
    assign addr_oe = addr_stage_q & cpu_phase;
    assign data_oe = data_stage_q & cpu_phase;
endmodule

// File: rtl/frame_write_replayer.sv
module frame_write_replayer
    import fwr_pkg::*;
#(
    parameter int DEPTH   = 64,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int PTR_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_phase,
    input  logic              bus_avail,
    input  logic              frame_sync,
    input  logic [IDX_W-1:0]  cycles_per_frame,
    input  logic              ld_we,
    input  logic [SLOT_W-1:0] ld_slot,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [PTR_W-1:0]  sched_len,
    input  logic              arm,
    input  logic              host_reset,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              addr_oe,
    output logic [DATA_W-1:0] bus_data,
    output logic              data_oe,
    output logic              dma_n,
    output logic              reset_n,
    output logic              missed
);
    logic             phase_q;
    logic             cycle_start;
    logic             cycle_end;
    logic [IDX_W-1:0] frame_idx;
    logic             active_q;
    logic             late_q;
    logic             missed_q;
    logic             reset_n_q;
    logic [PTR_W-1:0] ptr_q;
    logic             pending;
    logic             due;
    logic             fire;
    sched_entry_t     cur_entry;

    assign cycle_start = cpu_phase & ~phase_q;
    assign cycle_end   = ~cpu_phase & phase_q;

    fwr_frame_counter u_counter (
        .clk              (clk),
        .rst              (rst),
        .cycle_end        (cycle_end),
        .frame_sync       (frame_sync),
        .cycles_per_frame (cycles_per_frame),
        .count            (frame_idx)
    );

    fwr_sched_mem #(.DEPTH(DEPTH)) u_table (
        .clk    (clk),
        .we     (ld_we),
        .wslot  (ld_slot),
        .wentry (make_entry(ld_index, ld_addr, ld_data)),
        .rslot  (ptr_q[SLOT_W-1:0]),
        .rentry (cur_entry)
    );

    assign pending = active_q && (ptr_q != sched_len);
    assign due     = pending && (late_q || (frame_idx == cur_entry.idx));
    assign fire    = !arm && cycle_start && due && bus_avail;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= 1'b0;
            active_q  <= 1'b0;
            late_q    <= 1'b0;
            missed_q  <= 1'b0;
            reset_n_q <= 1'b1;
            ptr_q     <= '0;
        end else begin
            phase_q   <= cpu_phase;
            reset_n_q <= ~host_reset;
            if (arm) begin
                active_q <= (sched_len != '0);
                ptr_q    <= '0;
                late_q   <= 1'b0;
                missed_q <= 1'b0;
            end else if (active_q) begin
                if (cycle_start && due) begin
                    if (bus_avail) begin
                        ptr_q  <= ptr_q + PTR_W'(1);
                        late_q <= 1'b0;
                    end else begin
                        late_q   <= 1'b1;
                        missed_q <= 1'b1;
                    end
                end
                if (!pending && !cpu_phase) active_q <= 1'b0;
            end
        end
    end

    fwr_bus_driver u_driver (
        .clk       (clk),
        .rst       (rst),
        .cpu_phase (cpu_phase),
        .fire      (fire),
        .entry     (cur_entry),
        .bus_addr  (bus_addr),
        .addr_oe   (addr_oe),
        .bus_data  (bus_data),
        .data_oe   (data_oe)
    );

    assign dma_n   = ~active_q;
    assign reset_n = reset_n_q;
    assign missed  = missed_q;
endmodule

// File: rtl/fwr_checker.sv
module fwr_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_phase,
    input logic        host_reset,
    input logic        arm,
    input logic        addr_oe,
    input logic        data_oe,
    input logic        dma_n,
    input logic        missed,
    input logic        reset_n,
    input logic [15:0] bus_addr
);
    assert_oe_cpu_half_R6: assert property (@(posedge clk) disable iff (rst)
        (addr_oe || data_oe) |-> cpu_phase);

    assert_data_needs_addr_R6: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> addr_oe);

    assert_data_lags_addr_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> $past(addr_oe));

    assert_drive_needs_dma_R2: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> !dma_n);

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_oe && $past(addr_oe)) |-> $stable(bus_addr));

    assert_missed_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (missed && !arm) |=> missed);

    assert_reset_follows_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (reset_n == !$past(host_reset)));
endmodule

bind frame_write_replayer fwr_checker u_chk (.*);

// File: tb/sim_frame_write_replayer.sv
`timescale 1ns/1ps
module sim_frame_write_replayer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_phase = 1'b0;
    logic        bus_avail = 1'b1;
    logic        frame_sync = 1'b0;
    logic [14:0] cycles_per_frame = 15'd10;
    logic        ld_we = 1'b0;
    logic [5:0]  ld_slot = '0;
    logic [14:0] ld_index = '0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [6:0]  sched_len = '0;
    logic        arm = 1'b0;
    logic        host_reset = 1'b0;
    logic [15:0] bus_addr;
    logic        addr_oe;
    logic [7:0]  bus_data;
    logic        data_oe;
    logic        dma_n;
    logic        reset_n;
    logic        missed;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic        s_lo_oe, s_dma, s_aoe1, s_doe1, s_aoe2, s_doe2, s_missed;
    logic [15:0] s_addr;
    logic [7:0]  s_data;

    always #2 clk = ~clk;

    frame_write_replayer u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    // One host cycle: four clocks of video half, then four clocks of CPU half
    task automatic host_cycle(input logic sync);
        s_lo_oe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 1 && i <= 4 && (addr_oe || data_oe)) s_lo_oe = 1'b1;
            if (i == 2) s_dma = dma_n;
            if (i == 5) begin s_aoe1 = addr_oe; s_doe1 = data_oe; end
            if (i == 6) begin
                s_aoe2 = addr_oe; s_doe2 = data_oe;
                s_addr = bus_addr; s_data = bus_data;
            end
            if (i == 7) s_missed = missed;
            cpu_phase  = (i >= 4);
            frame_sync = sync && (i == 1);
        end
    endtask

    task automatic expect_cycle(input string req, input logic fires,
                                input logic [15:0] a, input logic [7:0] d);
        check({req, " addr_oe first CPU clock"}, s_aoe1, fires);
        check("R6 data_oe one clock later than addr_oe", s_doe1, 1'b0);
        check({req, " data_oe in CPU half"}, s_doe2, fires);
        check("R6 no drive in video half", s_lo_oe, 1'b0);
        if (fires) begin
            check({req, " R5 address"}, s_addr, a);
            check({req, " R6 data"}, s_data, d);
        end
    endtask

    task automatic load(input int slot, input logic [14:0] idx,
                        input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_slot = 6'(slot); ld_index = idx; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic do_arm(input int len);
        @(negedge clk);
        sched_len = 7'(len); arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dma_n after reset", dma_n, 1'b1);
        check("R1 addr_oe after reset", addr_oe, 1'b0);
        check("R1 data_oe after reset", data_oe, 1'b0);
        check("R1 reset_n after reset", reset_n, 1'b1);
        check("R1 missed after reset", missed, 1'b0);
    endtask

    task automatic t_basic();
        cycles_per_frame = 15'd10; bus_avail = 1'b1;
        load(0, 15'd2, 16'hD020, 8'h05);
        load(1, 15'd3, 16'hD021, 8'h06);
        load(2, 15'd6, 16'h1234, 8'hAB);
        do_arm(3);
        check("R2 dma_n low after arm", dma_n, 1'b0);
        for (int k = 0; k < 8; k++) begin
            host_cycle(k == 0);
            case (k)
                2: expect_cycle("R4 R10 slot0", 1'b1, 16'hD020, 8'h05);
                3: expect_cycle("R4 R10 slot1", 1'b1, 16'hD021, 8'h06);
                6: expect_cycle("R4 R10 slot2", 1'b1, 16'h1234, 8'hAB);
                default: expect_cycle("R4 idle cycle", 1'b0, 16'h0, 8'h0);
            endcase
            if (k <= 6) check("R2 dma_n held during replay", s_dma, 1'b0);
        end
        check("R8 dma_n released after last slot", s_dma, 1'b1);
    endtask

    task automatic t_wrap();
        cycles_per_frame = 15'd4; bus_avail = 1'b1;
        load(0, 15'd3, 16'h0400, 8'h11);
        load(1, 15'd1, 16'h0401, 8'h22);
        do_arm(2);
        for (int k = 0; k < 7; k++) begin
            host_cycle(k == 0);
            case (k)
                3: expect_cycle("R3 R4 first slot", 1'b1, 16'h0400, 8'h11);
                5: expect_cycle("R3 wrapped second slot", 1'b1, 16'h0401, 8'h22);
                default: expect_cycle("R4 slot order holds", 1'b0, 16'h0, 8'h0);
            endcase
        end
        check("R8 released after wrap replay", s_dma, 1'b1);
    endtask

    task automatic t_missed();
        cycles_per_frame = 15'd10; bus_avail = 1'b1;
        load(0, 15'd2, 16'hD011, 8'h1B);
        load(1, 15'd5, 16'hD016, 8'hC8);
        do_arm(2);
        for (int k = 0; k < 7; k++) begin
            bus_avail = (k != 2);
            host_cycle(k == 0);
            case (k)
                2: begin
                    expect_cycle("R7 no drive without bus", 1'b0, 16'h0, 8'h0);
                    check("R7 missed set", s_missed, 1'b1);
                end
                3: expect_cycle("R7 late slot fires", 1'b1, 16'hD011, 8'h1B);
                5: expect_cycle("R7 next slot on time", 1'b1, 16'hD016, 8'hC8);
                default: expect_cycle("R7 quiet cycle", 1'b0, 16'h0, 8'h0);
            endcase
            if (k < 2) check("R7 missed clear before fault", s_missed, 1'b0);
            if (k > 2) check("R7 missed sticky", s_missed, 1'b1);
        end
        do_arm(0);
        check("R2 missed cleared by arm", missed, 1'b0);
        check("R2 zero length keeps dma_n high", dma_n, 1'b1);
        host_cycle(1'b1);
        expect_cycle("R2 zero length drives nothing", 1'b0, 16'h0, 8'h0);
    endtask

    task automatic t_sync();
        cycles_per_frame = 15'd20; bus_avail = 1'b1;
        load(0, 15'd4, 16'hBEEF, 8'h5A);
        do_arm(1);
        for (int k = 0; k < 9; k++) begin
            host_cycle(k == 0 || k == 3);
            if (k == 7) expect_cycle("R3 sync restarts count", 1'b1, 16'hBEEF, 8'h5A);
            else        expect_cycle("R3 no fire before resync index", 1'b0, 16'h0, 8'h0);
        end
        check("R8 dma_n after single slot", s_dma, 1'b1);
    endtask

    task automatic t_host_reset();
        @(negedge clk); host_reset = 1'b1;
        @(negedge clk);
        check("R9 reset_n low one clock after request", reset_n, 1'b0);
        @(negedge clk);
        check("R9 reset_n held low", reset_n, 1'b0);
        host_reset = 1'b0;
        @(negedge clk);
        check("R9 reset_n released", reset_n, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_missed();
        t_sync();
        t_host_reset();
        finish_run();
    end
endmodule